// File: doc/BRIEF.md
# Gated-Counter Key Scanner

This block reads up to 32 individual push keys through one shared return line. A free-running scan counter walks through the key positions, one position per scan tick. The counter value is decoded onto an active-low select bus, and only the key at the current position is driven. Every key returns to a single active-low sense input. When the selected key is closed, the sense line goes low.

While the synchronised sense line is low, the counter stops advancing, so the frozen count is itself the key code. No priority encoder is needed. The first key reached while closed wins, and it keeps the scanner until it has been released for a full debounce interval.

A press is accepted only after the sense line has been low for a set number of consecutive scan ticks. On acceptance the block raises a single-cycle strobe. The code is reported at press time and needs no release.

Top module: `key_scanner`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `key_code` is 0, `key_stb` is low, and only `sel_n[0]` is low.
- R2: At all times exactly one bit of `sel_n` is low, and it is the bit indexed by `key_code`.
- R3: With no key closed, `key_code` increases by one every `TICK_DIV` clock cycles. After `KEYS-1` it wraps to 0, and it never changes by any other step.
- R4: With no key closed, one full pass over all positions takes exactly `KEYS*TICK_DIV` clock cycles. The default `TICK_DIV` of 4096 gives more than 100 passes per second at any clock of 13.2 MHz or faster.
- R5: While the sense line (after a two-flop synchroniser) is low, `key_code` does not change, however long the key is held.
- R6: A press is accepted only once sense has been seen low on `PRESS_TICKS` consecutive scan ticks. A shorter low produces no strobe.
- R7: Each accepted press gives exactly one `key_stb` pulse, one clock wide, with the pressed position on `key_code`. The pulse comes while the key is still held.
- R8: A second key closed while the first is held is not reported, and `key_code` keeps the first key's position.
- R9: After a release, scanning resumes only when sense has been high on `RELEASE_TICKS` consecutive ticks. A shorter high gap gives no new strobe. On resumption the code steps to the next position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sense_n | input | 1 | Shared key return line, low when the selected key is closed |
| sel_n | output | KEYS | One-hot active-low key select |
| key_code | output | $clog2(KEYS) | Current scan position, frozen while a key is held |
| key_stb | output | 1 | One-cycle pulse when a press is accepted |

## Verification
The bench builds the scanner with `TICK_DIV` = 4, `PRESS_TICKS` = 3 and `RELEASE_TICKS` = 4. With these values a full pass takes only 128 cycles, so wrap-around, the exact pass period, and presses at positions 5, 10, 20 and 31 all fit within a few hundred cycles each. The short tick also means the bench can time a deliberate one-tick press glitch and a three-cycle release gap against both debounce windows. It can then show that neither gives a strobe or an early resume, while real presses and releases still do.

// File: rtl/key_scan_pkg.sv
package key_scan_pkg;
    // Scanner control states
    typedef enum logic [1:0] {
        ST_SCAN  = 2'd0,   // counter running
        ST_PRESS = 2'd1,   // counting low ticks before acceptance
        ST_HELD  = 2'd2    // code reported, waiting for stable release
    } scan_st_e;
endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
    parameter int DIV = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/sense_sync.sv
module sense_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_n,
    output logic pressed
);
    logic [1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[0], sense_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 2'b11;
        else        sh_q <= sh_d;
    end

    assign pressed = ~sh_q[1];
endmodule

// File: rtl/sel_decode.sv
module sel_decode #(
    parameter int KEYS   = 32,
    parameter int CODE_W = $clog2(KEYS)
) (
    input  logic [CODE_W-1:0] code,
    output logic [KEYS-1:0]   sel_n
);
    for (genvar i = 0; i < KEYS; i++) begin : g_sel
        assign sel_n[i] = (code != CODE_W'(i));
    end
endmodule

// File: rtl/key_scanner.sv
module key_scanner
    import key_scan_pkg::*;
#(
    parameter int KEYS          = 32,
    parameter int TICK_DIV      = 4096,
    parameter int PRESS_TICKS   = 3,
    parameter int RELEASE_TICKS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sense_n,
    output logic [KEYS-1:0]         sel_n,
    output logic [$clog2(KEYS)-1:0] key_code,
    output logic                    key_stb
);
    localparam int CODE_W = $clog2(KEYS);
    localparam int PW     = $clog2(PRESS_TICKS + 1);
    localparam int RW     = $clog2(RELEASE_TICKS + 1);

    typedef struct packed {
        scan_st_e          st;
        logic [CODE_W-1:0] code;
        logic [PW-1:0]     lo_cnt;
        logic [RW-1:0]     hi_cnt;
        logic              stb;
    } scan_regs_t;

    scan_regs_t r_d, r_q;
    logic       tick;
    logic       pressed;

    scan_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sense_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sense_n (sense_n),
        .pressed (pressed)
    );

    sel_decode #(.KEYS(KEYS), .CODE_W(CODE_W)) u_dec (
        .code  (r_q.code),
        .sel_n (sel_n)
    );

    function automatic logic [CODE_W-1:0] next_pos(input logic [CODE_W-1:0] c);
        return (c == CODE_W'(KEYS - 1)) ? '0 : c + 1'b1;
    endfunction

    always_comb begin
        r_d     = r_q;
        r_d.stb = 1'b0;
        if (tick) begin
            unique case (r_q.st)
                ST_SCAN: begin
                    if (pressed) begin
                        r_d.lo_cnt = PW'(1);
                        if (PRESS_TICKS <= 1) begin
                            r_d.st     = ST_HELD;
                            r_d.stb    = 1'b1;
                            r_d.hi_cnt = '0;
                        end else begin
                            r_d.st = ST_PRESS;
                        end
                    end else begin
                        r_d.code = next_pos(r_q.code);
                    end
                end
                ST_PRESS: begin
                    if (!pressed) begin
                        r_d.st = ST_SCAN;
                    end else if (r_q.lo_cnt == PW'(PRESS_TICKS - 1)) begin
                        r_d.st     = ST_HELD;
                        r_d.stb    = 1'b1;
                        r_d.hi_cnt = '0;
                    end else begin
                        r_d.lo_cnt = r_q.lo_cnt + 1'b1;
                    end
                end
                ST_HELD: begin
                    if (pressed) begin
                        r_d.hi_cnt = '0;
                    end else if (r_q.hi_cnt == RW'(RELEASE_TICKS - 1)) begin
                        r_d.st     = ST_SCAN;
                        r_d.hi_cnt = '0;
                        r_d.code   = next_pos(r_q.code);
                    end else begin
                        r_d.hi_cnt = r_q.hi_cnt + 1'b1;
                    end
                end
                default: r_d.st = ST_SCAN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_SCAN;
            r_q.code   <= '0;
            r_q.lo_cnt <= '0;
            r_q.hi_cnt <= '0;
            r_q.stb    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign key_code = r_q.code;
    assign key_stb  = r_q.stb;
endmodule

// File: rtl/key_scanner_chk.sv
module key_scanner_chk #(
    parameter int KEYS   = 32,
    parameter int CODE_W = $clog2(KEYS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sense_n,
    input logic [KEYS-1:0]   sel_n,
    input logic [CODE_W-1:0] key_code,
    input logic              key_stb
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (key_code == '0 && !key_stb));

    // R2
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sel_n) == 1);

    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && key_code != $past(key_code)) |->
        (key_code == (($past(key_code) == CODE_W'(KEYS - 1)) ? '0 : $past(key_code) + 1'b1)));

    // R5
    frozen_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(sense_n)) |=> $stable(key_code));

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_stb |=> !key_stb);

    // R7
    strobe_on_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_stb && $past(rst_n)) |-> $stable(key_code));
endmodule

bind key_scanner key_scanner_chk #(.KEYS(KEYS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sense_n  (sense_n),
    .sel_n    (sel_n),
    .key_code (key_code),
    .key_stb  (key_stb)
);

// File: tb/key_scanner_test.sv
module key_scanner_test;
    localparam int KEYS = 32;
    localparam int CW   = 5;
    localparam int TD   = 4;
    localparam int PT   = 3;
    localparam int RT   = 4;
    localparam int PASS = KEYS * TD;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [KEYS-1:0] keys_down = '0;
    logic            sense_n;
    logic [KEYS-1:0] sel_n;
    logic [CW-1:0]   key_code;
    logic            key_stb;
    int              n_chk = 0;
    int              n_bad = 0;

    always #4 clk = ~clk;

    // Key matrix model: a closed key pulls the line low only while selected
    assign sense_n = ~|(~sel_n & keys_down);

    key_scanner #(.KEYS(KEYS), .TICK_DIV(TD), .PRESS_TICKS(PT), .RELEASE_TICKS(RT)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sense_n  (sense_n),
        .sel_n    (sel_n),
        .key_code (key_code),
        .key_stb  (key_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for a strobe; returns cycles waited, or -1 on timeout
    task automatic wait_stb(input int limit, output int waited);
        waited = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (key_stb) begin waited = i; return; end
        end
    endtask

    task automatic t_reset;
        check("R1 code in reset", key_code, 0);
        check("R1 strobe in reset", key_stb, 0);
        check("R1 select in reset", sel_n, {{(KEYS-1){1'b1}}, 1'b0});
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 code after reset", key_code, 0);
    endtask

    task automatic t_idle_scan;
        int bad_sel = 0, bad_step = 0, steps = 0, wraps = 0, prev;
        prev = key_code;
        for (int i = 0; i < 2 * PASS; i++) begin
            @(negedge clk);
            if (sel_n != ~(KEYS'(1) << key_code)) bad_sel++;
            if (key_code != prev) begin
                steps++;
                if (key_code != ((prev + 1) % KEYS)) bad_step++;
                if (prev == KEYS - 1) wraps++;
                prev = key_code;
            end
        end
        check("R2 select matches code", bad_sel, 0);
        check("R3 steps of one", bad_step, 0);
        check("R3 step count over two passes", steps, 2 * KEYS);
        check("R3 wrap to zero", wraps, 2);
    endtask

    task automatic t_period;
        int start = -1, len = 0, prev;
        prev = key_code;
        while (start < 0) begin
            @(negedge clk);
            if (key_code == 0 && prev != 0) start = 0;
            prev = key_code;
        end
        do begin
            @(negedge clk);
            len++;
            if (key_code == 0 && prev != 0) break;
            prev = key_code;
        end while (len < 4 * PASS);
        check("R4 full pass length", len, PASS);
    endtask

    task automatic t_press_hold(input int k, input int other);
        int w, extra = 0, moved = 0;
        keys_down[k] = 1'b1;
        wait_stb(3 * PASS, w);
        check("R7 strobe seen", (w >= 0) ? 1 : 0, 1);
        check("R7 code at strobe", key_code, k);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (key_stb) extra++;
            if (key_code != k) moved++;
        end
        check("R5 code frozen while held", moved, 0);
        check("R7 single strobe per press", extra, 0);
        keys_down[other] = 1'b1;
        extra = 0; moved = 0;
        for (int i = 0; i < 2 * PASS; i++) begin
            @(negedge clk);
            if (key_stb) extra++;
            if (key_code != k) moved++;
        end
        check("R8 second key not reported", extra, 0);
        check("R8 first key keeps code", moved, 0);
        keys_down[other] = 1'b0;
    endtask

    task automatic t_release_gap(input int k);
        int extra = 0, moved = 0;
        keys_down[k] = 1'b0;
        cycles(3);
        keys_down[k] = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (key_stb) extra++;
            if (key_code != k) moved++;
        end
        check("R9 short gap keeps code", moved, 0);
        check("R9 short gap no strobe", extra, 0);
    endtask

    task automatic t_release(input int k);
        int w = -1;
        keys_down[k] = 1'b0;
        cycles(10);
        check("R9 held through release debounce", key_code, k);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (key_code != k) begin w = i; break; end
        end
        check("R9 resumes to next position", key_code, (k + 1) % KEYS);
        check("R9 resume happened", (w >= 0) ? 1 : 0, 1);
    endtask

    task automatic t_glitch;
        int w;
        keys_down[10] = 1'b1;
        while (key_code != 10) @(negedge clk);
        cycles(4);
        keys_down[10] = 1'b0;
        wait_stb(40, w);
        check("R6 short low gives no strobe", (w >= 0) ? 1 : 0, 0);
        cycles(PASS);
        check("R6 scan not frozen after glitch", (key_code != 10) ? 1 : 0, 1);
    endtask

    task automatic t_reset_mid;
        int w;
        keys_down[7] = 1'b1;
        wait_stb(3 * PASS, w);
        check("R7 code seven", key_code, 7);
        rst_n = 1'b0;
        cycles(3);
        check("R1 code cleared mid hold", key_code, 0);
        check("R1 strobe low mid hold", key_stb, 0);
        check("R1 select zero mid hold", sel_n[0], 0);
        keys_down[7] = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        cycles(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cycles(3);
        t_reset;
        t_idle_scan;
        t_period;
        t_press_hold(5, 20);
        t_release_gap(5);
        t_release(5);
        t_glitch;
        t_press_hold(31, 2);
        t_release(31);
        t_reset_mid;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule